// File: doc/BRIEF.md
# Dual-Channel Pattern Fill Engine

The block holds two independent fill channels that paint a repeating pattern over a byte range of memory. Software programs a channel through a small register write port (base address, limit address, pattern word and a control word), then sets the go bit in the control word. The channel walks a byte pointer from the base towards the limit, issuing one byte-enabled write per step. A step is 2, 3 or 4 bytes wide, depending on the width flags captured with the go bit.

Both channels share one memory write port. A fixed-priority arbiter always grants channel 0 when it requests. A channel that is not granted holds its pointer and resumes where it stopped. When a channel finishes, it drops its busy flag, sets its finished flag and pulses its own interrupt line for one cycle. There is one exception: a base address of zero means "do nothing". Such a request still completes and sets finished, but it makes no memory write and raises no interrupt.

Top module: `fill_engine`

## Requirements
- R1: After reset, all busy flags, finished flags and interrupt lines are low, and no memory write is issued.
- R2: A write to register select 3 (control) with bit 0 set, aimed at an idle channel, starts a fill. The channel's busy output is high from the next cycle until the fill ends.
- R3: With control bits 2 and 3 both clear, each step writes a 16-bit unit. The byte enable is 4'b0011, the low 16 bits of the pattern (register select 2) appear on wdata[15:0], and the pointer advances by 2.
- R4: With control bit 3 set and bit 2 clear, each step writes 32 bits. The byte enable is 4'b1111, the data is the whole pattern, and the pointer advances by 4.
- R5: With control bit 2 set, each step writes three bytes at the pointer, pointer+1 and pointer+2. These are pattern bits [7:0], [15:8] and [23:16] on lanes 0 to 2, with byte enable 4'b0111, and the pointer advances by 3. Bit 2 wins over bit 3 when both are set.
- R6: A step is issued only while the pointer is below the limit (register select 1), taken unsigned; the last step may cross the limit. If the base is at or above the limit, the fill makes no write but still completes with an interrupt.
- R7: If the base (register select 0) is zero, the fill makes no write and raises no interrupt. Busy still clears and finished (control bit 1) still sets.
- R8: When a fill with a nonzero base ends, busy clears, finished sets, and that channel's interrupt line is high for exactly one cycle.
- R9: A control write with bit 1 clear resets the finished flag. A control write with bit 1 set and bit 0 clear leaves it unchanged.
- R10: While a channel is busy, every register write to it is ignored: the running fill is not altered, no extra fill starts, and the base and limit stay as they were for later fills.
- R11: When both channels request the port, channel 0 is granted and channel 1 stalls. Channel 1 then completes its range with no write lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_chan | input | CW | Target channel of the register write |
| cfg_sel | input | 2 | Register select: 0 base, 1 limit, 2 pattern, 3 control |
| cfg_wdata | input | 32 | Register write data |
| mem_we | output | 1 | Memory write valid this cycle |
| mem_addr | output | AW | Byte address of lane 0 |
| mem_wdata | output | 32 | Write data; lane k goes to mem_addr+k |
| mem_be | output | 4 | Byte lane enables |
| chan_busy | output | NCH | Per-channel busy (go bit still set) |
| chan_done | output | NCH | Per-channel finished flag |
| chan_irq | output | NCH | Per-channel one-cycle completion pulse |

## Verification
The bench aims at several corner cases:
- A limit that is not a multiple of the step size, where a wrong compare drops the last step or adds one more.
- The 24-bit mode with both width flags set, where wrong precedence writes four bytes and steps by 4.
- A zero base, where a wrong design either paints memory from address 0 or raises a stray interrupt.
- An empty range, where a wrong design drops the interrupt.
- Config writes to a busy channel, which a faulty block would apply to the running fill or to the next one.
- Channel 1 starting one cycle before channel 0, where a design that advanced the pointer on request instead of on grant would leave holes in channel 1's range.

// File: rtl/fill_pkg.sv
package fill_pkg;

  typedef enum logic [1:0] {
    REG_BASE    = 2'd0,
    REG_LIMIT   = 2'd1,
    REG_PATTERN = 2'd2,
    REG_CTRL    = 2'd3
  } reg_sel_e;

  localparam int CTL_GO   = 0;
  localparam int CTL_DONE = 1;
  localparam int CTL_W24  = 2;
  localparam int CTL_W32  = 3;

  // Bytes consumed per step; the 24-bit flag has precedence.
  function automatic logic [2:0] step_bytes(input logic w24, input logic w32);
    if (w24)      return 3'd3;
    else if (w32) return 3'd4;
    else          return 3'd2;
  endfunction

  function automatic logic [3:0] lane_mask(input logic w24, input logic w32);
    if (w24)      return 4'b0111;
    else if (w32) return 4'b1111;
    else          return 4'b0011;
  endfunction

  // Pattern bytes sit little-endian on the lanes; disabled lanes are zeroed.
  function automatic logic [31:0] lane_data(input logic [31:0] pat, input logic [3:0] m);
    logic [31:0] d;
    for (int k = 0; k < 4; k++) d[8*k +: 8] = m[k] ? pat[8*k +: 8] : 8'h00;
    return d;
  endfunction

endpackage

// File: rtl/fill_chan.sv
module fill_chan
  import fill_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic          gnt,
  output logic          req,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_word,
  output logic [3:0]    wr_mask,
  output logic          busy,
  output logic          done,
  output logic          irq
);

  logic [AW-1:0] base_q, limit_q, ptr_q;
  logic [31:0]   pat_q;
  logic          w24_q, w32_q, trig_q, done_q, irq_q;

  // Named events for the assertions
  logic in_range, zero_base, step_taken, fill_end, quiet_end;

  assign zero_base  = (base_q == '0);
  assign in_range   = (ptr_q < limit_q);
  assign req        = trig_q && !zero_base && in_range;
  assign step_taken = req && gnt;
  assign fill_end   = trig_q && !zero_base && !in_range;
  assign quiet_end  = trig_q && zero_base;

  assign wr_addr = ptr_q;
  assign wr_mask = lane_mask(w24_q, w32_q);
  assign wr_word = lane_data(pat_q, wr_mask);
  assign busy    = trig_q;
  assign done    = done_q;
  assign irq     = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
      ptr_q   <= '0;
      pat_q   <= '0;
      w24_q   <= 1'b0;
      w32_q   <= 1'b0;
      trig_q  <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (trig_q) begin
        if (quiet_end) begin
          trig_q <= 1'b0;
          done_q <= 1'b1;
        end else if (fill_end) begin
          trig_q <= 1'b0;
          done_q <= 1'b1;
          irq_q  <= 1'b1;
        end else if (step_taken) begin
          ptr_q <= ptr_q + AW'(step_bytes(w24_q, w32_q));
        end
      end else if (wr_en) begin
        unique case (reg_sel_e'(wr_sel))
          REG_BASE:    base_q  <= wr_data[AW-1:0];
          REG_LIMIT:   limit_q <= wr_data[AW-1:0];
          REG_PATTERN: pat_q   <= wr_data;
          REG_CTRL: begin
            w24_q  <= wr_data[CTL_W24];
            w32_q  <= wr_data[CTL_W32];
            done_q <= done_q & wr_data[CTL_DONE];
            if (wr_data[CTL_GO]) begin
              trig_q <= 1'b1;
              ptr_q  <= base_q;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  busy_cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && trig_q) |=> (base_q == $past(base_q)) && (limit_q == $past(limit_q))
                          && (pat_q == $past(pat_q)));
  // R7
  zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && zero_base) |=> (!trig_q && done_q && !irq_q));
  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R8
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (done_q && !trig_q));
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt) |=> (ptr_q == $past(ptr_q)));

endmodule

// File: rtl/fill_arb.sv
module fill_arb #(
  parameter int NCH = 2,
  parameter int AW  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           req,
  input  logic [NCH-1:0][AW-1:0]   addr,
  input  logic [NCH-1:0][31:0]     word,
  input  logic [NCH-1:0][3:0]      mask,
  output logic [NCH-1:0]           gnt,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [31:0]              mem_wdata,
  output logic [3:0]               mem_be
);

  // Lowest index wins: isolate the least significant request bit.
  assign gnt    = req & (~req + NCH'(1));
  assign mem_we = |req;

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gnt[i]) begin
        mem_addr  = addr[i];
        mem_wdata = word[i];
        mem_be    = mask[i];
      end
    end
  end

  // R11
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R11
  chan0_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> gnt[0]);

endmodule

// File: rtl/fill_engine.sv
module fill_engine #(
  parameter int NCH = 2,
  parameter int AW  = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CW-1:0]  cfg_chan,
  input  logic [1:0]     cfg_sel,
  input  logic [31:0]    cfg_wdata,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  output logic [3:0]     mem_be,
  output logic [NCH-1:0] chan_busy,
  output logic [NCH-1:0] chan_done,
  output logic [NCH-1:0] chan_irq
);

  logic [NCH-1:0]         ch_req, ch_gnt;
  logic [NCH-1:0][AW-1:0] ch_addr;
  logic [NCH-1:0][31:0]   ch_word;
  logic [NCH-1:0][3:0]    ch_mask;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    fill_chan #(.AW(AW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (cfg_chan == CW'(i))),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_wdata),
      .gnt     (ch_gnt[i]),
      .req     (ch_req[i]),
      .wr_addr (ch_addr[i]),
      .wr_word (ch_word[i]),
      .wr_mask (ch_mask[i]),
      .busy    (chan_busy[i]),
      .done    (chan_done[i]),
      .irq     (chan_irq[i])
    );
  end

  fill_arb #(.NCH(NCH), .AW(AW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (ch_req),
    .addr      (ch_addr),
    .word      (ch_word),
    .mask      (ch_mask),
    .gnt       (ch_gnt),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be)
  );

endmodule

// File: tb/fill_engine_bench.sv
module fill_engine_bench;
  localparam int AW = 32;
  localparam int NCH = 2;
  localparam int MSZ = 512;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_we;
  logic [0:0] cfg_chan;
  logic [1:0] cfg_sel;
  logic [31:0] cfg_wdata;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0] mem_be;
  logic [NCH-1:0] chan_busy, chan_done, chan_irq;

  fill_engine u_fill_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .chan_busy(chan_busy), .chan_done(chan_done), .chan_irq(chan_irq)
  );

  int checks = 0, fails = 0;
  logic [7:0] got_mem [0:MSZ-1];
  logic [7:0] exp_mem [0:MSZ-1];
  int wr_cnt, irq0_cnt, irq1_cnt;
  int arb_arm = 0, first0, last0, first1, min1_after;
  int mon_bytes_bad;

  // Memory and interrupt monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MSZ; i++) got_mem[i] = 8'h00;
      wr_cnt = 0; irq0_cnt = 0; irq1_cnt = 0; mon_bytes_bad = 0;
    end else begin
      if (arb_arm == 0) begin
        first0 = -1; last0 = -1; first1 = -1; min1_after = -1;
      end
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) got_mem[(int'(mem_addr[8:0]) + k) % MSZ] = mem_wdata[8*k +: 8];
        if (arb_arm != 0) begin
          if (mem_addr >= 16 && mem_addr < 80) begin
            if (first0 < 0) first0 = wr_cnt;
            last0 = wr_cnt;
          end else if (mem_addr >= 128 && mem_addr < 160) begin
            if (first1 < 0) first1 = wr_cnt;
            if (first0 >= 0 && min1_after < 0) min1_after = wr_cnt;
          end
        end
        wr_cnt++;
      end
      irq0_cnt += int'(chan_irq[0]);
      irq1_cnt += int'(chan_irq[1]);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input int ch, input int sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_chan = ch[0]; cfg_sel = sel[1:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle(input int ch);
    @(negedge clk);
    while (chan_busy[ch]) @(negedge clk);
    @(negedge clk);
  endtask

  // Reference fill; returns number of steps
  task automatic model(input int b, input int lim, input logic [31:0] v,
                       input bit w24, input bit w32, output int steps);
    int p, n;
    steps = 0;
    if (b == 0) return;
    n = w24 ? 3 : (w32 ? 4 : 2);
    p = b;
    while (p < lim) begin
      for (int k = 0; k < n; k++) exp_mem[(p + k) % MSZ] = v[8*k +: 8];
      p += n;
      steps++;
    end
  endtask

  task automatic mem_cmp(input string req);
    int bad = -1;
    for (int i = 0; i < MSZ; i++)
      if (bad < 0 && got_mem[i] !== exp_mem[i]) bad = i;
    if (bad < 0) check(1'b1, req, "memory image", 0, 0);
    else check(1'b0, req, $sformatf("memory byte %0d", bad),
               longint'(got_mem[bad]), longint'(exp_mem[bad]));
  endtask

  function automatic int irq_of(input int ch);
    return (ch == 0) ? irq0_cnt : irq1_cnt;
  endfunction

  // mode bit0 = 24-bit flag, bit1 = 32-bit flag
  task automatic run_fill(input int ch, input int b, input int lim, input logic [31:0] v,
                          input int mode, input string req, input bit count_chk);
    int steps, w0, i0;
    w0 = wr_cnt; i0 = irq_of(ch);
    cfg_wr(ch, 0, b);
    cfg_wr(ch, 1, lim);
    cfg_wr(ch, 2, v);
    cfg_wr(ch, 3, (mode << 2) | 1);
    check(chan_busy[ch] == 1'b1, "R2", "busy after go", chan_busy[ch], 1);
    model(b, lim, v, mode[0], mode[1], steps);
    wait_idle(ch);
    mem_cmp(req);
    if (count_chk) check(wr_cnt - w0 == steps, req, "write count", wr_cnt - w0, steps);
    check(irq_of(ch) - i0 == ((b != 0) ? 1 : 0), "R8", "irq pulses",
          irq_of(ch) - i0, (b != 0) ? 1 : 0);
    check(chan_done[ch] == 1'b1 && chan_busy[ch] == 1'b0, "R8", "done/busy",
          {chan_done[ch], chan_busy[ch]}, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R2: fill never went idle (got hung expected idle)");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int w0, i0, i1;
    void'($urandom(32'd4711));
    for (int i = 0; i < MSZ; i++) exp_mem[i] = 8'h00;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_chan = '0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(chan_busy == 0 && chan_done == 0 && chan_irq == 0 && mem_we == 0, "R1",
          "reset outputs", {chan_busy, chan_done, chan_irq, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(chan_busy == 0 && chan_done == 0 && mem_we == 0, "R1", "after release",
          {chan_busy, chan_done, mem_we}, 0);

    run_fill(0, 20, 30, 32'hA1B2C3D4, 0, "R3", 1);   // 16-bit, 5 steps
    run_fill(1, 40, 57, 32'h0badf00d, 2, "R4", 1);   // 32-bit, limit not aligned
    run_fill(0, 60, 70, 32'h00cafe42, 1, "R5", 1);   // 24-bit
    run_fill(1, 80, 89, 32'h77665544, 3, "R5", 1);   // both flags -> 24-bit
    run_fill(0, 100, 100, 32'hffffffff, 2, "R6", 1); // empty range
    run_fill(1, 110, 105, 32'hffffffff, 0, "R6", 1); // base above limit

    // R7 zero base
    w0 = wr_cnt; i0 = irq0_cnt;
    cfg_wr(0, 3, 0);
    cfg_wr(0, 0, 0);
    cfg_wr(0, 1, 50);
    cfg_wr(0, 2, 32'h12345678);
    cfg_wr(0, 3, 32'h9);
    wait_idle(0);
    check(wr_cnt == w0, "R7", "writes with zero base", wr_cnt - w0, 0);
    check(irq0_cnt == i0, "R7", "irq with zero base", irq0_cnt - i0, 0);
    check(chan_done[0] == 1'b1 && chan_busy[0] == 1'b0, "R7", "done/busy",
          {chan_done[0], chan_busy[0]}, 2);
    mem_cmp("R7");

    // R9 finished flag handling
    cfg_wr(0, 3, 32'h2);
    @(negedge clk);
    check(chan_done[0] == 1'b1, "R9", "done kept by bit1=1", chan_done[0], 1);
    cfg_wr(0, 3, 32'h0);
    @(negedge clk);
    check(chan_done[0] == 1'b0, "R9", "done cleared", chan_done[0], 0);

    // R10 writes while busy are ignored
    i0 = irq0_cnt;
    cfg_wr(0, 0, 300);
    cfg_wr(0, 1, 400);
    cfg_wr(0, 2, 32'h11223344);
    cfg_wr(0, 3, 32'h9);
    begin
      int s;
      model(300, 400, 32'h11223344, 1'b0, 1'b1, s);
    end
    cfg_wr(0, 0, 10);
    cfg_wr(0, 1, 500);
    cfg_wr(0, 2, 32'h55555555);
    cfg_wr(0, 3, 32'h5);
    wait_idle(0);
    mem_cmp("R10");
    check(irq0_cnt - i0 == 1, "R10", "single completion", irq0_cnt - i0, 1);
    cfg_wr(0, 2, 32'h99887766);
    cfg_wr(0, 3, 32'h9);
    begin
      int s;
      model(300, 400, 32'h99887766, 1'b0, 1'b1, s);
    end
    wait_idle(0);
    mem_cmp("R10");

    // R11 arbitration: channel 1 starts one cycle before channel 0
    cfg_wr(0, 0, 16); cfg_wr(0, 1, 80); cfg_wr(0, 2, 32'hdeadbeef);
    cfg_wr(1, 0, 128); cfg_wr(1, 1, 160); cfg_wr(1, 2, 32'h0000a55a);
    begin
      int s;
      model(16, 80, 32'hdeadbeef, 1'b0, 1'b1, s);
      model(128, 160, 32'h0000a55a, 1'b0, 1'b0, s);
    end
    arb_arm = 1;
    i0 = irq0_cnt; i1 = irq1_cnt;
    cfg_wr(1, 3, 32'h1);
    cfg_wr(0, 3, 32'h9);
    wait_idle(0);
    wait_idle(1);
    arb_arm = 0;
    mem_cmp("R11");
    check(first1 >= 0 && first1 < first0, "R11", "ch1 wrote first", first1, first0);
    check(min1_after > last0, "R11", "ch1 stalled during ch0", min1_after, last0 + 1);
    check(irq0_cnt - i0 == 1 && irq1_cnt - i1 == 1, "R11", "both complete",
          (irq0_cnt - i0) + (irq1_cnt - i1), 2);

    // Random fills (R2..R6)
    for (int n = 0; n < 10; n++) begin
      int ch, b, len, mode;
      logic [31:0] v;
      ch = int'($urandom % 2);
      b = 1 + int'($urandom % 400);
      len = int'($urandom % 49);
      mode = int'($urandom % 4);
      v = $urandom;
      cfg_wr(ch, 3, 0);
      run_fill(ch, b, b + len, v, mode, "R2", 1);
    end

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule